// File: doc/BRIEF.md
# Dual-Compare PWM Timer

This block produces a pulse-width-modulated waveform on one output pin from a 16-bit up-counter and two 16-bit compare registers. A clock prescaler divides the system clock into counter ticks. The period register ends each cycle: when the counter reaches it, the pin takes one configured level and the counter restarts at FFFCh, not at zero. The edge register places the pulse edge inside the cycle: when the counter reaches it, the pin takes the other configured level. Each cycle is therefore (period + 5) ticks long. Compare values are ordered from FFFCh upward through FFFFh and on into 0000h.

Software programs the block through a byte-wide write port. It selects the two match levels, the prescaler, the run bit and the pin enable. It loads each compare register as a high byte and a low byte. A compare is held off between the write of its high byte and the write of its low byte, so a half-written value never fires. Every period match sets a match flag, and software clears that flag by writing a 1 to it. The flag raises an interrupt when either of two enables is set.

Top module: `pwm_dual_cmp`

Register map (address on `wr_addr`):
- 0: control. Bit 0 is the edge-match level, bit 1 the period-match level, bit 2 the pin enable, bit 3 run, bit 4 one-shot select, bits 6:5 the prescaler code.
- 1: interrupt enables. Bit 0 is the global compare enable, bit 1 the period-match enable.
- 2: status. Writing 1 to bit 0 clears the match flag.
- 4 and 5: period register, high byte then low byte.
- 6 and 7: edge register, high byte then low byte.

## Requirements
- R1: While running, a tick on which the counter equals an armed period register drives the waveform level to control bit 1 and reloads the counter to FFFCh. The waveform period is therefore (period + 5) ticks.
- R2: A tick on which the counter equals the armed edge register, and does not equal the period register, drives the level to control bit 0. With bit 0 = 0 and bit 1 = 1 the high time is (edge + 5) mod 65536 ticks. With bit 0 = 1 and bit 1 = 0 the high time is (period − edge) ticks.
- R3: Prescaler code 00 gives one tick per 4 clocks, 01 one per 2 clocks and 10 one per 8 clocks. Code 11 gives no ticks, so the counter, the flag and the pin all stay unchanged.
- R4: Every period match sets the match flag. Writing 1 to status bit 0 clears it.
- R5: `irq` is high exactly when the match flag is set and at least one of the two interrupt enable bits is 1.
- R6: After a write to the high byte of either compare register, that compare produces no event until the low byte of the same register is written.
- R7: With the period register at FFFCh, the counter stays at FFFCh, the pin stays at the period-match level, and the flag keeps being set.
- R8: With the edge register at FFFCh, the edge event fires on the first tick after each reload, giving a one-tick pulse.
- R9: If the edge value comes later than the period value in the FFFCh-first order, no edge event occurs and the pin stays at the period-match level.
- R10: The one-shot select bit has no effect while the run bit is set.
- R11: After reset the pin, the flag and `irq` are 0. The pin is 0 whenever the pin-enable bit is 0.
- R12: While the run bit is 0, the counter holds at FFFCh and no match occurs, so the flag stays clear and the pin level holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 1 | Waveform pin, gated by the pin enable |
| cmp_flag | output | 1 | Period-match flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit counter reloading to FFFCh and a 3-bit prescaler divider. Small compare values keep every waveform cycle under a few hundred clocks. At these values all three dividers, both level polarities, the edge value at the reload point, and an edge value placed past the period can each be measured edge to edge in a short run. The reload offset of five ticks shows directly in each measured period.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    typedef enum logic [1:0] {
        PS_DIV4 = 2'b00,
        PS_DIV2 = 2'b01,
        PS_DIV8 = 2'b10,
        PS_HALT = 2'b11
    } presc_e;

    // Control byte layout, most significant field first (bit 7 unused).
    typedef struct packed {
        presc_e presc;
        logic   one_shot;
        logic   run;
        logic   oe;
        logic   lvl_b;   // level applied on a period match
        logic   lvl_a;   // level applied on an edge match
    } ctrl_t;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_IE     = 3'd1;
    localparam logic [2:0] A_STAT   = 3'd2;
    localparam logic [2:0] A_PER_HI = 3'd4;
    localparam logic [2:0] A_PER_LO = 3'd5;
    localparam logic [2:0] A_PW_HI  = 3'd6;
    localparam logic [2:0] A_PW_LO  = 3'd7;

    // Mask of low divider bits that must all be 1 for a tick.
    function automatic logic [2:0] presc_mask(presc_e p);
        case (p)
            PS_DIV2: presc_mask = 3'b001;
            PS_DIV4: presc_mask = 3'b011;
            PS_DIV8: presc_mask = 3'b111;
            default: presc_mask = 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/pwmt_presc.sv
module pwmt_presc
    import pwmt_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run,
    input  presc_e presc,
    output logic   tick
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
    } st_t;

    st_t st_d, st_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask     = DIV_W'(presc_mask(presc));
        tick     = run && (presc != PS_HALT) && ((st_q.div & mask) == mask);
        st_d     = st_q;
        st_d.div = run ? st_q.div + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwmt_regs.sv
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int          CNT_W  = 16,
    parameter logic [15:0] RELOAD = 16'hFFFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [7:0]       wr_data,
    output ctrl_t            ctrl,
    output logic             ie_all,
    output logic             ie_per,
    output logic [CNT_W-1:0] per_val,
    output logic [CNT_W-1:0] pw_val,
    output logic             per_arm,
    output logic             pw_arm,
    output logic             flag_clr
);
    localparam int HI_W   = CNT_W - 8;
    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t            ctrl;
        logic             ie_all;
        logic             ie_per;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] pw;
        logic             per_arm;
        logic             pw_arm;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        flag_clr = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL:   st_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
                A_IE:     begin
                              st_d.ie_all = wr_data[0];
                              st_d.ie_per = wr_data[1];
                          end
                A_STAT:   flag_clr = wr_data[0];
                A_PER_HI: begin
                              st_d.per[CNT_W-1:8] = wr_data[HI_W-1:0];
                              st_d.per_arm        = 1'b0;
                          end
                A_PER_LO: begin
                              st_d.per[7:0] = wr_data;
                              st_d.per_arm  = 1'b1;
                          end
                A_PW_HI:  begin
                              st_d.pw[CNT_W-1:8] = wr_data[HI_W-1:0];
                              st_d.pw_arm        = 1'b0;
                          end
                A_PW_LO:  begin
                              st_d.pw[7:0] = wr_data;
                              st_d.pw_arm  = 1'b1;
                          end
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.per     <= CNT_W'(RELOAD);
            st_q.pw      <= CNT_W'(RELOAD);
            st_q.per_arm <= 1'b1;
            st_q.pw_arm  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl    = st_q.ctrl;
    assign ie_all  = st_q.ie_all;
    assign ie_per  = st_q.ie_per;
    assign per_val = st_q.per;
    assign pw_val  = st_q.pw;
    assign per_arm = st_q.per_arm;
    assign pw_arm  = st_q.pw_arm;
endmodule

// File: rtl/pwmt_core.sv
module pwmt_core #(
    parameter int          CNT_W  = 16,
    parameter logic [15:0] RELOAD = 16'hFFFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] per_val,
    input  logic [CNT_W-1:0] pw_val,
    input  logic             per_arm,
    input  logic             pw_arm,
    input  logic             lvl_a,
    input  logic             lvl_b,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             level,
    output logic             flag,
    output logic             per_hit
);
    localparam logic [CNT_W-1:0] START = CNT_W'(RELOAD);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             level;
        logic             flag;
    } st_t;

    st_t  st_d, st_q;
    logic pw_hit;

    always_comb begin
        per_hit = run && tick && per_arm && (st_q.cnt == per_val);
        pw_hit  = run && tick && pw_arm && (st_q.cnt == pw_val) && !per_hit;
        st_d    = st_q;
        if (!run) begin
            st_d.cnt = START;
        end else if (per_hit) begin
            st_d.cnt   = START;
            st_d.level = lvl_b;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (pw_hit) st_d.level = lvl_a;
        end
        if (per_hit)       st_d.flag = 1'b1;
        else if (flag_clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= START;
            st_q.level <= 1'b0;
            st_q.flag  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt   = st_q.cnt;
    assign level = st_q.level;
    assign flag  = st_q.flag;
endmodule

// File: rtl/pwm_dual_cmp.sv
module pwm_dual_cmp
    import pwmt_pkg::*;
#(
    parameter int          CNT_W  = 16,
    parameter int          DIV_W  = 3,
    parameter logic [15:0] RELOAD = 16'hFFFC
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       pwm_out,
    output logic       cmp_flag,
    output logic       irq
);
    ctrl_t            ctrl;
    logic             ie_all, ie_per;
    logic [CNT_W-1:0] per_val, pw_val;
    logic             per_arm, pw_arm, flag_clr;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             level, flag, per_hit;

    pwmt_regs #(.CNT_W(CNT_W), .RELOAD(RELOAD)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl), .ie_all(ie_all), .ie_per(ie_per),
        .per_val(per_val), .pw_val(pw_val), .per_arm(per_arm),
        .pw_arm(pw_arm), .flag_clr(flag_clr)
    );

    pwmt_presc #(.DIV_W(DIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .presc(ctrl.presc),
        .tick(tick)
    );

    pwmt_core #(.CNT_W(CNT_W), .RELOAD(RELOAD)) u_core (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick(tick),
        .per_val(per_val), .pw_val(pw_val), .per_arm(per_arm),
        .pw_arm(pw_arm), .lvl_a(ctrl.lvl_a), .lvl_b(ctrl.lvl_b),
        .flag_clr(flag_clr), .cnt(cnt), .level(level), .flag(flag),
        .per_hit(per_hit)
    );

    assign pwm_out  = ctrl.oe & level;
    assign cmp_flag = flag;
    assign irq      = flag & (ie_all | ie_per);
endmodule

// File: rtl/pwmt_chk.sv
module pwmt_chk
    import pwmt_pkg::*;
#(
    parameter int          CNT_W  = 16,
    parameter logic [15:0] RELOAD = 16'hFFFC
) (
    input logic             clk,
    input logic             rst_n,
    input ctrl_t            ctrl,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per_val,
    input logic [CNT_W-1:0] pw_val,
    input logic             per_arm,
    input logic             pw_arm,
    input logic             per_hit,
    input logic             level,
    input logic             flag,
    input logic             irq,
    input logic             pwm_out
);
    localparam logic [CNT_W-1:0] START = CNT_W'(RELOAD);

    p_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
        per_hit |=> cnt == START);
    p_perlvl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        per_hit |=> level == $past(ctrl.lvl_b));
    p_edgelvl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.run && tick && pw_arm && cnt == pw_val && !per_hit)
            |=> level == $past(ctrl.lvl_a));
    p_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.presc == PS_HALT |-> !tick);
    p_flagset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        per_hit |=> flag);
    p_irqflag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);
    p_holdoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pw_arm && !per_hit) |=> $stable(level));
    p_stuck_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (per_arm && per_val == START && cnt == START) |=> cnt == START);
    p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.oe |-> !pwm_out);
    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.run |=> cnt == START);
endmodule

bind pwm_dual_cmp pwmt_chk #(.CNT_W(CNT_W), .RELOAD(RELOAD)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .tick(tick), .cnt(cnt),
    .per_val(per_val), .pw_val(pw_val), .per_arm(per_arm), .pw_arm(pw_arm),
    .per_hit(per_hit), .level(level), .flag(flag), .irq(irq),
    .pwm_out(pwm_out)
);

// File: tb/sim_pwm_dual_cmp.sv
`timescale 1ns/1ps
module sim_pwm_dual_cmp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pwm_out, cmp_flag, irq;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    pwm_dual_cmp u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .cmp_flag(cmp_flag), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  presc;
        logic        opm;
        logic        lvl_a;
        logic        lvl_b;
        logic [15:0] per;
        logic [15:0] pw;
        logic [11:0] exp_hi;
        logic [11:0] exp_per;
    } vec_t;

    // Steady-state high time and period in clocks, from R1, R2, R3, R8, R10.
    localparam vec_t VEC [6] = '{
        '{2'b00, 1'b0, 1'b0, 1'b1, 16'd20,    16'd6,     12'd44, 12'd100},
        '{2'b01, 1'b0, 1'b0, 1'b1, 16'd11,    16'd3,     12'd16, 12'd32},
        '{2'b10, 1'b0, 1'b0, 1'b1, 16'd7,     16'd1,     12'd48, 12'd96},
        '{2'b00, 1'b0, 1'b1, 1'b0, 16'd20,    16'd6,     12'd56, 12'd100},
        '{2'b01, 1'b0, 1'b0, 1'b1, 16'd9,     16'hFFFC,  12'd2,  12'd28},
        '{2'b00, 1'b1, 1'b0, 1'b1, 16'd20,    16'd6,     12'd44, 12'd100}
    };

    function automatic logic [7:0] cbyte(logic la, logic lb, logic oe,
                                         logic run, logic opm, logic [1:0] ps);
        return {1'b0, ps, opm, run, oe, lb, la};
    endfunction

    task automatic check(logic ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cmp(logic [15:0] per, logic [15:0] pw);
        wr(3'd4, per[15:8]); wr(3'd5, per[7:0]);
        wr(3'd6, pw[15:8]);  wr(3'd7, pw[7:0]);
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    // Counts samples where the pin differs from the expected steady value.
    task automatic steady(logic exp, int n, string tag);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out !== exp) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic measure(output int hi, output int per_c);
        logic prev;
        int   g;
        hi = 0; per_c = 0; g = 0;
        @(negedge clk); prev = pwm_out;
        forever begin
            @(negedge clk); g++;
            if (!prev && pwm_out) break;
            prev = pwm_out;
            if (g > 3000) break;
        end
        while (pwm_out && g < 6000) begin hi++; @(negedge clk); g++; end
        per_c = hi;
        while (!pwm_out && g < 9000) begin per_c++; @(negedge clk); g++; end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hi, pc;
        logic held;
        wait_clk(3);
        // R11: reset state
        check(pwm_out == 1'b0, "R11 reset pin", pwm_out, 0);
        check(cmp_flag == 1'b0, "R4 reset flag", cmp_flag, 0);
        check(irq == 1'b0, "R5 reset irq", irq, 0);
        rst_n = 1'b1;
        wait_clk(2);

        foreach (VEC[i]) begin
            wr(3'd0, cbyte(VEC[i].lvl_a, VEC[i].lvl_b, 1'b1, 1'b0, VEC[i].opm, VEC[i].presc));
            set_cmp(VEC[i].per, VEC[i].pw);
            wr(3'd0, cbyte(VEC[i].lvl_a, VEC[i].lvl_b, 1'b1, 1'b1, VEC[i].opm, VEC[i].presc));
            measure(hi, pc);
            measure(hi, pc);
            check(hi == int'(VEC[i].exp_hi), $sformatf("R2 R8 R10 high time vec %0d", i), hi, VEC[i].exp_hi);
            check(pc == int'(VEC[i].exp_per), $sformatf("R1 R3 period vec %0d", i), pc, VEC[i].exp_per);
        end

        // R11: pin gated off while running
        wr(3'd0, cbyte(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00));
        set_cmp(16'd20, 16'd6);
        wr(3'd0, cbyte(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00));
        steady(1'b0, 300, "R11 pin with enable clear");

        // R4/R5: flag set by earlier matches, no enables
        check(cmp_flag == 1'b1, "R4 flag after matches", cmp_flag, 1);
        check(irq == 1'b0, "R5 irq no enable", irq, 0);
        wr(3'd0, cbyte(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00));
        wr(3'd2, 8'h01);
        check(cmp_flag == 1'b0, "R4 write-one clear", cmp_flag, 0);
        held = pwm_out;
        steady(held, 200, "R12 pin holds while stopped");
        check(cmp_flag == 1'b0, "R12 no match while stopped", cmp_flag, 0);
        wr(3'd1, 8'h02);
        check(irq == 1'b0, "R5 irq flag clear", irq, 0);
        wr(3'd0, cbyte(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00));
        wait_clk(150);
        check(irq == 1'b1, "R5 irq period enable", irq, 1);
        wr(3'd1, 8'h01);
        check(irq == 1'b1, "R5 irq global enable", irq, 1);
        wr(3'd1, 8'h00);
        check(irq == 1'b0, "R5 irq enables clear", irq, 0);

        // R3: halt code freezes everything
        wr(3'd0, cbyte(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b11));
        wr(3'd2, 8'h01);
        wr(3'd0, cbyte(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11));
        held = pwm_out;
        steady(held, 300, "R3 halt pin steady");
        check(cmp_flag == 1'b0, "R3 halt no match", cmp_flag, 0);

        // R6: high-byte write holds off the edge compare
        wr(3'd0, cbyte(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00));
        wr(3'd6, 8'h00);
        wait_clk(120);
        steady(1'b1, 300, "R6 edge held off");
        wr(3'd7, 8'd6);
        measure(hi, pc);
        measure(hi, pc);
        check(hi == 44, "R6 edge rearmed high", hi, 44);

        // R9: edge placed after period
        wr(3'd0, cbyte(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01));
        set_cmp(16'd5, 16'd10);
        wr(3'd0, cbyte(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b01));
        wait_clk(60);
        steady(1'b1, 200, "R9 no edge event");

        // R7: period at reload value sticks
        wr(3'd0, cbyte(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01));
        wr(3'd2, 8'h01);
        set_cmp(16'hFFFC, 16'd6);
        wr(3'd0, cbyte(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b01));
        wait_clk(20);
        steady(1'b1, 200, "R7 stuck no waveform");
        check(cmp_flag == 1'b1, "R7 flag still set", cmp_flag, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule